// File: doc/BRIEF.md
# Signed 4-bit Add/Subtract Unit with Seven-Segment Readout

This block takes two 4-bit two's-complement operands from an 8-bit switch bank and either adds them or subtracts the second from the first. A single held button picks the operation. The arithmetic runs through a ripple-carry chain of full-adder cells built from gate equations. No behavioural `+` or `-` is used anywhere in the datapath. The chain also flags signed overflow.

Six seven-segment digits show the values as three sign/magnitude pairs: the first operand, the second operand and the result. Each magnitude is shown in decimal. When the result overflows, the result pair shows "0F" instead of a value. The eight LEDs that sit next to the switches are held dark. The block is purely combinational.

Top module: `addsub_disp_top`

## Requirements
- R1: The first operand is `sw_i[7:4]` and the second operand is `sw_i[3:0]`. Each is read as a two's-complement value in the range -8..+7.
- R2: While `sub_hold_i` is 0, the result is the sum of the first and second operands.
- R3: While `sub_hold_i` is 1, the result is the first operand minus the second operand.
- R4: If the true result lies outside -8..+7, `hex1_o` shows the digit 0 (7'h3F) and `hex0_o` shows the letter F (7'h71).
- R5: Each sign digit shows 7'h00 (all segments dark) for a value of zero or more, and 7'h40 (middle bar only) for a negative value. `hex5_o` carries the sign of the first operand, `hex3_o` the sign of the second operand, and `hex1_o` the sign of a result that did not overflow.
- R6: Each magnitude digit (`hex4_o` for the first operand, `hex2_o` for the second, `hex0_o` for a result that did not overflow) shows the absolute value in decimal. The value -8 shows as 8.
- R7: Segment codes put segment a in bit 0 through segment g in bit 6, and a 1 lights the segment. The decimal digits 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F (hex).
- R8: `led_o` is always 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sw_i | input | 8 | Operand switches; upper nibble is the first operand, lower nibble is the second |
| sub_hold_i | input | 1 | 1 selects subtraction, 0 selects addition |
| hex5_o | output | 7 | Sign of the first operand |
| hex4_o | output | 7 | Magnitude of the first operand |
| hex3_o | output | 7 | Sign of the second operand |
| hex2_o | output | 7 | Magnitude of the second operand |
| hex1_o | output | 7 | Sign of the result, or "0" on overflow |
| hex0_o | output | 7 | Magnitude of the result, or "F" on overflow |
| led_o | output | 8 | LEDs, held off |

## Verification
The bench sweeps all 256 operand pairs in both modes. This exercises the edges that a faulty chain gets wrong:
- **-8 as an operand.** A magnitude unit that negates naively would show 0 for -8 instead of 8.
- **Subtracting -8.** Every such case overflows unless the first operand is negative. A design that inverted the subtrahend but forgot the carry-in would show a value one off.
- **Sums that reach exactly -8.** These must not be flagged, so an overflow test based on the carry out alone would wrongly show "0F".
- **Mixed-sign additions.** These never overflow, and a sign digit wired to the wrong bit would show a minus on a positive result.

// File: rtl/addsub_disp_pkg.sv
package addsub_disp_pkg;
  localparam int OPW = 4;
  localparam int SEGW = 7;

  localparam logic [SEGW-1:0] SEG_BLANK = 7'h00;
  localparam logic [SEGW-1:0] SEG_MINUS = 7'h40;
  localparam logic [SEGW-1:0] SEG_LTR_F = 7'h71;
  localparam logic [SEGW-1:0] SEG_ZERO  = 7'h3F;

  // Decimal digit to segment pattern, bit0 = a ... bit6 = g, active high.
  function automatic logic [SEGW-1:0] dec_to_seg(input logic [OPW-1:0] d);
    logic [SEGW-1:0] s;
    case (d)
      4'd0: s = 7'h3F;
      4'd1: s = 7'h06;
      4'd2: s = 7'h5B;
      4'd3: s = 7'h4F;
      4'd4: s = 7'h66;
      4'd5: s = 7'h6D;
      4'd6: s = 7'h7D;
      4'd7: s = 7'h07;
      4'd8: s = 7'h7F;
      4'd9: s = 7'h6F;
      default: s = SEG_BLANK;
    endcase
    return s;
  endfunction

  // Absolute value of a two's-complement word, read back as unsigned.
  // Negation is invert-then-increment with a bitwise carry walk, so the
  // most negative code maps to itself and reads as its unsigned magnitude.
  function automatic logic [OPW-1:0] twos_mag(input logic [OPW-1:0] v);
    logic [OPW-1:0] inv;
    logic [OPW-1:0] m;
    logic c;
    if (!v[OPW-1]) return v;
    inv = ~v;
    c = 1'b1;
    for (int i = 0; i < OPW; i++) begin
      m[i] = inv[i] ^ c;
      c    = inv[i] & c;
    end
    return m;
  endfunction
endpackage

// File: rtl/fa_cell.sv
module fa_cell (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic half_x;
  assign half_x = a_i ^ b_i;
  assign s_o    = half_x ^ c_i;
  assign c_o    = (a_i & b_i) | (half_x & c_i);
endmodule

// File: rtl/addsub_ripple.sv
module addsub_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         ovf_o
);
  logic [W-1:0] b_eff;
  logic [W:0]   carry;

  assign b_eff    = b_i ^ {W{sub_i}};
  assign carry[0] = sub_i;

  for (genvar g = 0; g < W; g++) begin : g_stage
    fa_cell u_fa (
      .a_i(a_i[g]),
      .b_i(b_eff[g]),
      .c_i(carry[g]),
      .s_o(res_o[g]),
      .c_o(carry[g+1])
    );
  end

  assign ovf_o = carry[W] ^ carry[W-1];

  // Overflow seen from the signs: like-signed effective inputs, unlike result.
  always_comb begin
    AST_OVF_SIGN_RULE: assert (ovf_o == ((a_i[W-1] == b_eff[W-1]) && (res_o[W-1] != a_i[W-1]))); // R4
  end
endmodule

// File: rtl/signed_digit_pair.sv
module signed_digit_pair
  import addsub_disp_pkg::*;
(
  input  logic [OPW-1:0]  val_i,
  input  logic            ovf_i,
  output logic [SEGW-1:0] sign_seg_o,
  output logic [SEGW-1:0] mag_seg_o
);
  logic [OPW-1:0] mag;
  logic           is_neg;

  assign is_neg = val_i[OPW-1];
  assign mag    = twos_mag(val_i);

  always_comb begin
    if (ovf_i) begin
      sign_seg_o = SEG_ZERO;
      mag_seg_o  = SEG_LTR_F;
    end else begin
      sign_seg_o = is_neg ? SEG_MINUS : SEG_BLANK;
      mag_seg_o  = dec_to_seg(mag);
    end
  end

  always_comb begin
    AST_SIGN_SHAPE: assert (ovf_i || $onehot0(sign_seg_o) && (sign_seg_o[5:0] == 6'd0)); // R5
    AST_MAG_LIT: assert (ovf_i || mag_seg_o != SEG_BLANK); // R6
    AST_NEG_NONZERO: assert (ovf_i || !is_neg || mag_seg_o != SEG_ZERO); // R6
  end
endmodule

// File: rtl/addsub_disp_top.sv
module addsub_disp_top
  import addsub_disp_pkg::*;
(
  input  logic [7:0]      sw_i,
  input  logic            sub_hold_i,
  output logic [SEGW-1:0] hex5_o,
  output logic [SEGW-1:0] hex4_o,
  output logic [SEGW-1:0] hex3_o,
  output logic [SEGW-1:0] hex2_o,
  output logic [SEGW-1:0] hex1_o,
  output logic [SEGW-1:0] hex0_o,
  output logic [7:0]      led_o
);
  logic [OPW-1:0] op_a;
  logic [OPW-1:0] op_b;
  logic [OPW-1:0] res;
  logic           res_ovf;

  assign op_a = sw_i[2*OPW-1:OPW];
  assign op_b = sw_i[OPW-1:0];

  addsub_ripple #(.W(OPW)) u_arith (
    .a_i  (op_a),
    .b_i  (op_b),
    .sub_i(sub_hold_i),
    .res_o(res),
    .ovf_o(res_ovf)
  );

  signed_digit_pair u_disp_a (
    .val_i(op_a), .ovf_i(1'b0), .sign_seg_o(hex5_o), .mag_seg_o(hex4_o)
  );
  signed_digit_pair u_disp_b (
    .val_i(op_b), .ovf_i(1'b0), .sign_seg_o(hex3_o), .mag_seg_o(hex2_o)
  );
  signed_digit_pair u_disp_r (
    .val_i(res), .ovf_i(res_ovf), .sign_seg_o(hex1_o), .mag_seg_o(hex0_o)
  );

  assign led_o = '0;

  always_comb begin
    AST_NO_OVERFLOW: assert (res_ovf || hex1_o == (res[OPW-1] ? SEG_MINUS : SEG_BLANK)); // R5
    AST_OVF_DIGITS: assert (!res_ovf || (hex1_o == SEG_ZERO && hex0_o == SEG_LTR_F)); // R4
    AST_OP_A_SIGN: assert (hex5_o == (sw_i[7] ? SEG_MINUS : SEG_BLANK)); // R1
  end
endmodule

// File: tb/addsub_disp_top_tb.sv
module addsub_disp_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] sw = 8'h00;
  logic       sub_hold = 1'b0;
  logic [6:0] h5, h4, h3, h2, h1, h0;
  logic [7:0] led;
  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  addsub_disp_top dut_i (
    .sw_i(sw), .sub_hold_i(sub_hold),
    .hex5_o(h5), .hex4_o(h4), .hex3_o(h3), .hex2_o(h2),
    .hex1_o(h1), .hex0_o(h0), .led_o(led)
  );

  function automatic logic [6:0] exp_digit(input int d);
    logic [6:0] tbl [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                             7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};
    return tbl[d];
  endfunction

  function automatic int to_signed4(input logic [3:0] n);
    return (n >= 8) ? int'(n) - 16 : int'(n);
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s sw=%02h sub=%0b act=%02h exp=%02h", tag, sw, sub_hold, act, exp);
    end
  endtask

  task automatic check_vector();
    int a, b, r;
    a = to_signed4(sw[7:4]);
    b = to_signed4(sw[3:0]);
    r = sub_hold ? a - b : a + b;
    check("R1_sign_a", {1'b0, h5}, (a < 0) ? 8'h40 : 8'h00);
    check("R6_mag_a", {1'b0, h4}, {1'b0, exp_digit(a < 0 ? -a : a)});
    check("R5_sign_b", {1'b0, h3}, (b < 0) ? 8'h40 : 8'h00);
    check("R6_mag_b", {1'b0, h2}, {1'b0, exp_digit(b < 0 ? -b : b)});
    check("R8_led", led, 8'h00);
    if (r > 7 || r < -8) begin
      check("R4_ovf_hi", {1'b0, h1}, 8'h3F);
      check("R4_ovf_lo", {1'b0, h0}, 8'h71);
    end else begin
      check(sub_hold ? "R3_sign" : "R2_sign", {1'b0, h1}, (r < 0) ? 8'h40 : 8'h00);
      check(sub_hold ? "R3_mag" : "R2_mag", {1'b0, h0}, {1'b0, exp_digit(r < 0 ? -r : r)});
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset-state pattern: all switches down, add mode. R7 digit 0 code.
    check("R7_reset_h4", {1'b0, h4}, 8'h3F);
    check("R5_reset_h5", {1'b0, h5}, 8'h00);
    check("R2_reset_h0", {1'b0, h0}, 8'h3F);
    // Directed corners
    sw = 8'h88; sub_hold = 1'b0; @(negedge clk); check("R4_m8_plus_m8", {1'b0, h0}, 8'h71);
    sw = 8'h18; sub_hold = 1'b1; @(negedge clk); check("R3_1_minus_m8", {1'b0, h1}, 8'h3F);
    sw = 8'hF8; sub_hold = 1'b1; @(negedge clk); check("R3_m1_minus_m8", {1'b0, h0}, 8'h07);
    sw = 8'hC4; sub_hold = 1'b1; @(negedge clk); check("R6_m4_minus_4", {1'b0, h0}, 8'h7F);
    // Exhaustive sweep, one vector per clock
    for (int m = 0; m < 2; m++) begin
      for (int v = 0; v < 256; v++) begin
        @(posedge clk);
        #2;
        sw = v[7:0];
        sub_hold = m[0];
        @(negedge clk);
        check_vector();
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired act=running exp=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule